// File: doc/BRIEF.md
# Block-Count DMA Read Sequencer

This block fetches a run of 16-byte blocks from memory and delivers each one, whole, to a downstream engine such as a hash or authentication accumulator. Software programs a start address and then a control word. The control word holds a launch flag and a block count, stored as the number of blocks minus one. Software then polls the control word. The count is kept in the control word itself and steps down as blocks leave. After the final block the whole control word returns to zero, and software reads that zero as "finished".

Each block is read as four 32-bit words. One request is outstanding at a time. The words are packed into a 128-bit output with a valid/ready handshake. A new block is not fetched until the current one has been taken. An error response on the memory side freezes the transfer and flags it. Software then clears or relaunches the transfer with a fresh control write.

Top module: `blk_dma_seq`

## Requirements
- R1: After reset, the control and address registers read 0, and `mem_req_o` and `blk_valid_o` are low.
- R2: The control word (`reg_sel_i`=0) has these fields: bit 31 START, bit 30 BUSY, bit 29 ERR, and bits 11:0 the block count minus one. All other bits read 0. Writing START=1 while idle launches a transfer. From the next cycle BUSY reads 1, and BUSY never reads 1 without START.
- R3: Each block is read as four word requests at base, base+4, base+8 and base+12, in that order. A request holds `mem_req_o` high with a stable `mem_addr_o` until `mem_rvalid_i` arrives. Only one request is outstanding.
- R4: The word from the lowest address appears on `blk_data_o[31:0]` and the word from base+12 appears on `blk_data_o[127:96]`.
- R5: `blk_valid_o` stays high with stable data until `blk_ready_i`. No memory request is made while a block is waiting. The next block's first request comes no earlier than the cycle after the handshake.
- R6: Each output handshake advances the address register (`reg_sel_i`=1) by 16.
- R7: A handshake with a nonzero count decrements the count by one and leaves START and BUSY set.
- R8: A handshake with a zero count clears the whole control word to 0 and fetching stops. A count of N-1 moves exactly N blocks, up to 4096 blocks (65536 bytes) with count 0xFFF.
- R9: A response with `mem_rerr_i` set has several effects. ERR is set and BUSY clears. START, the count and the address keep their values. No further requests or blocks follow.
- R10: Writes to either register while BUSY reads 1 have no effect.
- R11: A control write while idle replaces the whole word and clears ERR. A write with START=0 only stores the count and launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control word, 1 address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| mem_req_o | output | 1 | Word read request, held until response |
| mem_addr_o | output | 32 | Byte address of the requested word |
| mem_rvalid_i | input | 1 | Response present for the held request |
| mem_rdata_i | input | 32 | Response word |
| mem_rerr_i | input | 1 | Response carries an error |
| blk_valid_o | output | 1 | Assembled block is available |
| blk_data_o | output | 128 | Assembled block, lowest-address word in low bits |
| blk_ready_i | input | 1 | Downstream takes the block |

## Verification
A corrupted count or address shows up quickly at the ports. It is visible on `mem_addr_o` at the next block's first request, and on the control or address readback in the cycle after a handshake. A bad fetch state shows as a request made while a block is waiting, or as a word index that skips or repeats an address. Either one appears within one word time. An error that is latched wrongly shows in the next cycle's control readback, as BUSY still set or START dropped. Because a reference model is compared on every clock, every such divergence is caught in the cycle it first reaches a port.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;
  localparam int CTRL_START_BIT = 31;
  localparam int CTRL_BUSY_BIT  = 30;
  localparam int CTRL_ERR_BIT   = 29;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_ADDR = 1'b1;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_FETCH = 2'd1,
    FS_HOLD  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import blk_dma_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int CNT_W     = 12,
  parameter int BLK_BYTES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             blk_done_i,
  input  logic             fetch_err_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [REG_W-1:0] addr_o
);
  logic             start_q, busy_q, err_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] addr_q;
  logic [REG_W-1:0] ctrl_word;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[CTRL_ERR_BIT-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else if (busy_q) begin
      if (fetch_err_i) begin
        err_q  <= 1'b1;
        busy_q <= 1'b0;
      end else if (blk_done_i) begin
        addr_q <= addr_q + REG_W'(BLK_BYTES);
        if (cnt_q == '0) begin
          start_q <= 1'b0;
          busy_q  <= 1'b0;
          err_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end else if (wr_i) begin
      if (sel_i == SEL_CTRL) begin
        start_q <= wdata_i[CTRL_START_BIT];
        busy_q  <= wdata_i[CTRL_START_BIT];
        err_q   <= 1'b0;
        cnt_q   <= wdata_i[CNT_W-1:0];
      end else begin
        addr_q <= wdata_i;
      end
    end
  end

  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[CTRL_START_BIT] = start_q;
    ctrl_word[CTRL_BUSY_BIT]  = busy_q;
    ctrl_word[CTRL_ERR_BIT]   = err_q;
    ctrl_word[CNT_W-1:0]      = cnt_q;
  end

  assign rdata_o = (sel_i == SEL_CTRL) ? ctrl_word : addr_q;
  assign busy_o  = busy_q;
  assign last_o  = (cnt_q == '0);
  assign addr_o  = addr_q;

  // R2
  busy_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> start_q);

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_i && !blk_done_i && !fetch_err_i) |=> ($stable(addr_q) && $stable(cnt_q)));

  // R9
  err_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && fetch_err_i) |=> (start_q && !busy_q && $stable(cnt_q) && $stable(addr_q)));
endmodule

// File: rtl/dma_fetch.sv
module dma_fetch
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    busy_i,
  input  logic                    last_i,
  input  logic [ADDR_W-1:0]       base_i,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  input  logic                    mem_rerr_i,
  output logic                    blk_valid_o,
  output logic [DATA_W*WORDS-1:0] blk_data_o,
  input  logic                    blk_ready_i,
  output logic                    blk_done_o,
  output logic                    err_o
);
  localparam int WIDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(WORDS - 1);

  fetch_state_e      state_q;
  logic [WIDX_W-1:0] widx_q;
  logic              word_ok;

  assign word_ok = (state_q == FS_FETCH) && mem_rvalid_i && !mem_rerr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      widx_q  <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (busy_i) begin
          state_q <= FS_FETCH;
          widx_q  <= '0;
        end
        FS_FETCH: if (mem_rvalid_i) begin
          if (mem_rerr_i)              state_q <= FS_IDLE;
          else if (widx_q == WIDX_LAST) state_q <= FS_HOLD;
          else                          widx_q  <= widx_q + 1'b1;
        end
        FS_HOLD: if (blk_ready_i) begin
          widx_q  <= '0;
          state_q <= last_i ? FS_IDLE : FS_FETCH;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  // one lane register per word, lowest address in the lowest lane
  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       lane_q <= '0;
      else if (word_ok && widx_q == WIDX_W'(g)) lane_q <= mem_rdata_i;
    end
    assign blk_data_o[g*DATA_W +: DATA_W] = lane_q;
  end

  assign mem_req_o   = (state_q == FS_FETCH);
  assign mem_addr_o  = base_i + ADDR_W'(widx_q) * ADDR_W'(WORD_BYTES);
  assign blk_valid_o = (state_q == FS_HOLD);
  assign blk_done_o  = blk_valid_o && blk_ready_i;
  assign err_o       = mem_req_o && mem_rvalid_i && mem_rerr_i;

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R5
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_o && !blk_ready_i) |=> (blk_valid_o && $stable(blk_data_o)));

  // R5
  one_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && blk_valid_o));

  // R9
  err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (!mem_req_o && !blk_valid_o));

  // R8
  active_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || blk_valid_o) |-> busy_i);
endmodule

// File: rtl/blk_dma_seq.sv
module blk_dma_seq #(
  parameter int REG_W         = 32,
  parameter int DATA_W        = 32,
  parameter int WORDS_PER_BLK = 4,
  parameter int CNT_W         = 12,
  localparam int BLK_W        = DATA_W * WORDS_PER_BLK,
  localparam int BLK_BYTES    = BLK_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              mem_req_o,
  output logic [REG_W-1:0]  mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rerr_i,
  output logic              blk_valid_o,
  output logic [BLK_W-1:0]  blk_data_o,
  input  logic              blk_ready_i
);
  logic             busy, last, blk_done, fetch_err;
  logic [REG_W-1:0] base_addr;

  dma_ctrl_regs #(
    .REG_W    (REG_W),
    .CNT_W    (CNT_W),
    .BLK_BYTES(BLK_BYTES)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .blk_done_i (blk_done),
    .fetch_err_i(fetch_err),
    .busy_o     (busy),
    .last_o     (last),
    .addr_o     (base_addr)
  );

  dma_fetch #(
    .ADDR_W(REG_W),
    .DATA_W(DATA_W),
    .WORDS (WORDS_PER_BLK)
  ) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .last_i      (last),
    .base_i      (base_addr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_rerr_i  (mem_rerr_i),
    .blk_valid_o (blk_valid_o),
    .blk_data_o  (blk_data_o),
    .blk_ready_i (blk_ready_i),
    .blk_done_o  (blk_done),
    .err_o       (fetch_err)
  );
endmodule

// File: tb/tb_blk_dma_seq.sv
module tb_blk_dma_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0]  reg_wdata = '0, reg_rdata;
  logic         mem_req, mem_rvalid = 1'b0, mem_rerr = 1'b0;
  logic [31:0]  mem_addr, mem_rdata = '0;
  logic         blk_valid, blk_ready = 1'b0;
  logic [127:0] blk_data;

  always #10 clk = ~clk;

  blk_dma_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .mem_rerr_i(mem_rerr),
    .blk_valid_o(blk_valid), .blk_data_o(blk_data), .blk_ready_i(blk_ready)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  // reference model
  bit          m_start = 0, m_busy = 0, m_err = 0;
  int          m_cnt = 0, m_phase = 0, m_word = 0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_buf [4] = '{default: '0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_busy = 0; m_err = 0; m_cnt = 0; m_phase = 0; m_word = 0; m_addr = '0;
      foreach (m_buf[i]) m_buf[i] = '0;
    end else begin
      automatic bit o_busy = m_busy;
      if (m_phase == 1 && mem_rvalid) begin
        if (mem_rerr) begin
          m_err = 1; m_busy = 0; m_phase = 0;
        end else begin
          m_buf[m_word] = mem_rdata;
          if (m_word == 3) m_phase = 2; else m_word++;
        end
      end else if (m_phase == 2 && blk_ready) begin
        m_addr += 32'd16;
        if (m_cnt == 0) begin
          m_start = 0; m_busy = 0; m_err = 0; m_phase = 0;
        end else begin
          m_cnt--; m_phase = 1; m_word = 0;
        end
      end else if (m_phase == 0 && o_busy) begin
        m_phase = 1; m_word = 0;
      end
      if (!o_busy && reg_wr) begin
        if (!reg_sel) begin
          m_start = reg_wdata[31]; m_busy = reg_wdata[31]; m_err = 0;
          m_cnt = int'(reg_wdata[11:0]);
        end else m_addr = reg_wdata;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!reg_sel) chk("R2 ctrl readback", reg_rdata, {m_start, m_busy, m_err, 17'b0, 12'(m_cnt)});
      else          chk("R6 addr readback", reg_rdata, m_addr);
      chk("R3 mem_req", mem_req, m_phase == 1);
      if (m_phase == 1) chk("R3 mem_addr", mem_addr, m_addr + 32'(4 * m_word));
      chk("R5 blk_valid", blk_valid, m_phase == 2);
      if (m_phase == 2) chk("R4 blk_data", blk_data, {m_buf[3], m_buf[2], m_buf[1], m_buf[0]});
    end
  end

  // memory and sink models
  int          lat_mode = 0, rdy_mode = 0, wait_c = 0, lat_seq = 0, rdy_seq = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  always @(negedge clk) begin
    #2;
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      mem_rerr   = 1'b0;
      lat_seq++;
      wait_c = (lat_mode == 0) ? 0 : (lat_seq % 3);
    end
    if (mem_req) begin
      if (wait_c == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(mem_addr);
        mem_rerr   = (mem_addr == err_addr);
      end else wait_c--;
    end
    rdy_seq++;
    case (rdy_mode)
      0:       blk_ready = 1'b1;
      1:       blk_ready = (rdy_seq % 4) == 3;
      default: blk_ready = 1'b0;
    endcase
  end

  task automatic tick();
    @(negedge clk); #2;
    reg_wr  = 1'b0;
    reg_sel = ~reg_sel;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); #2;
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
  endtask

  task automatic rd_chk(input logic sel, input logic [31:0] exp, input string tag);
    @(negedge clk); #2;
    reg_wr = 1'b0; reg_sel = sel;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    tick();
    for (int i = 0; i < 40000 && m_busy; i++) tick();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd_chk(1'b0, 32'h0, "R1 ctrl after reset");
    rd_chk(1'b1, 32'h0, "R1 addr after reset");
    chk("R1 mem_req after reset", mem_req, 1'b0);
    chk("R1 blk_valid after reset", blk_valid, 1'b0);

    // three blocks, fast memory, always ready
    wr(1'b1, 32'h0000_1000);
    wr(1'b0, 32'h8000_0002);
    rd_chk(1'b0, 32'hC000_0002, "R2 busy after launch");
    wait_idle();
    rd_chk(1'b0, 32'h0, "R8 ctrl cleared after last block");
    rd_chk(1'b1, 32'h0000_1030, "R6 addr after three blocks");

    // five blocks, slow memory, intermittent sink, writes while busy
    lat_mode = 1; rdy_mode = 1;
    wr(1'b1, 32'h0000_2040);
    wr(1'b0, 32'h8000_0004);
    repeat (12) tick();
    rd_chk(1'b0, {3'b110, 17'b0, 12'(m_cnt)}, "R7 count stepping while busy");
    wr(1'b1, 32'hDEAD_0000);
    wr(1'b0, 32'h0000_0000);
    tick();
    chk("R10 busy kept after ignored ctrl write", m_busy && dut.reg_rdata_o !== 32'hx, 1'b1);
    wait_idle();
    rd_chk(1'b1, 32'h0000_2090, "R10 addr unaffected by busy write");
    rd_chk(1'b0, 32'h0, "R8 ctrl cleared after five blocks");

    // error on block 1 word 2
    lat_mode = 0; rdy_mode = 0;
    err_addr = 32'h0000_3018;
    wr(1'b1, 32'h0000_3000);
    wr(1'b0, 32'h8000_0003);
    wait_idle();
    rd_chk(1'b0, 32'hA000_0002, "R9 ctrl after error");
    rd_chk(1'b1, 32'h0000_3010, "R9 addr after error");
    repeat (5) tick();
    chk("R9 no request after error", mem_req, 1'b0);
    chk("R9 no block after error", blk_valid, 1'b0);
    err_addr = 32'hFFFF_FFFF;
    wr(1'b0, 32'h0000_0005);
    rd_chk(1'b0, 32'h0000_0005, "R11 idle write clears err, no launch");
    repeat (3) tick();
    chk("R11 no request without start", mem_req, 1'b0);
    wr(1'b0, 32'h8000_0000);
    wait_idle();
    rd_chk(1'b1, 32'h0000_3020, "R8 single block moved");

    // sink stalls: block must wait, no fetch meanwhile
    rdy_mode = 2;
    wr(1'b1, 32'h0000_4000);
    wr(1'b0, 32'h8000_0001);
    repeat (20) tick();
    chk("R5 block waits for ready", blk_valid, 1'b1);
    chk("R5 no fetch while block waits", mem_req, 1'b0);
    chk("R4 low word from lowest address", blk_data[31:0], mem_word(32'h0000_4000));
    chk("R4 high word from base+12", blk_data[127:96], mem_word(32'h0000_400C));
    rdy_mode = 0;
    wait_idle();
    rd_chk(1'b1, 32'h0000_4020, "R6 addr after stalled pair");

    // largest transfer
    wr(1'b1, 32'h0001_0000);
    wr(1'b0, 32'h8000_0FFF);
    wait_idle();
    rd_chk(1'b0, 32'h0, "R8 ctrl cleared after 4096 blocks");
    rd_chk(1'b1, 32'h0002_0000, "R8 addr after 65536 bytes");

    repeat (4) tick();
    summary();
  end
endmodule